// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a processor's load/store port and a slower next-level memory. It holds a set of lines, each made of a valid flag, a tag and a block of several 32-bit words. The address is split into three fields. The byte offset picks a word inside the block. The index picks the single line that the block may occupy. The tag is compared with the tag stored in that line. A load that finds its line valid with a matching tag is answered in the same cycle. Any other load stalls the processor while the whole block is read from memory, and the load then completes from the cache.

Every store is written through to memory. It is first posted into a small first-in first-out store buffer, so the processor goes on at once unless that buffer is full. A store that hits also merges its bytes into the cached word. A build-time switch chooses what a store miss does. In allocate mode the block is fetched first and the store then proceeds as a hit. In write-around mode the store goes to memory only and the cache is left as it was. Before any block refill, the store buffer is drained, so a refill never returns data older than a posted store.

The memory side is a single request channel with a valid/ready handshake, carrying posted word writes and line-read requests. Refill words come back one per beat on a response strobe, in ascending word order.

Top module: `wt_dcache`

## Requirements
- R1: After reset every line is invalid and `cpu_ack` and `mem_req_valid` are low, so the first load to any line is a miss.
- R2: Address bits [3:2] select the word, bits [9:4] select the line and bits [31:10] form the tag. Byte address 1200 therefore uses line 11, and two addresses that differ only in the tag evict each other.
- R3: A load whose line is valid with a matching tag raises `cpu_ack` in the same cycle as `cpu_req`, returns the cached word on `cpu_rdata` and issues no memory read.
- R4: A load miss stalls and issues exactly one read request (`mem_req_we` = 0) at the line address with bits [3:0] zero. It takes four response words in ascending word order, and then completes with the refilled word.
- R5: Every store reaches memory as one write request (`mem_req_we` = 1) carrying the address with bits [1:0] cleared, the store data and the byte enables.
- R6: A store hit merges into the cached word only the bytes whose `cpu_be` bit is set, where bit i covers data bits [8i+7:8i].
- R7: The store buffer holds 4 entries. A store is accepted in its request cycle while the buffer has room, and stalls while the buffer is full until an entry drains to memory.
- R8: With ALLOC_ON_WMISS = 1, a store miss fetches the line before writing, so a following load to that line hits.
- R9: With ALLOC_ON_WMISS = 0, a store miss leaves the cache unchanged, so a following load to that line misses.
- R10: A refill read is issued only when the store buffer is empty, so a load after posted stores returns data that includes them.
- R11: Posted stores leave on the memory port in the order in which the processor issued them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until acknowledged |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_ack | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ack` |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = word write, 0 = line read |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_req_be | output | 4 | Write byte enables |
| mem_rsp_valid | input | 1 | Refill word strobe |
| mem_rsp_data | input | 32 | Refill word |

## Verification
A hit, and a store that finds room in the buffer, must raise `cpu_ack` in the request cycle itself. The bench drives each request on a falling edge and samples one nanosecond later, before the rising edge that completes it, and counts zero stalled cycles as a hit. A miss or a full-buffer stall is measured as the number of falling edges that pass before `cpu_ack`. Memory effects (read counts, line-aligned read addresses, write order and written contents) are read from the bench memory model once the request has completed, or after a settling window long enough to empty the buffer.

// File: rtl/wt_dcache_pkg.sv
package wt_dcache_pkg;

    // Controller states: serve hits, empty the store buffer, ask for a line, take the refill
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_REQ,
        ST_FILL
    } ctl_state_e;

endpackage

// File: rtl/wt_store_queue.sv
module wt_store_queue #(
    parameter int ENTRY_W = 68,
    parameter int DEPTH   = 4,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [ENTRY_W-1:0] push_data,
    input  logic               pop,
    output logic [ENTRY_W-1:0] head,
    output logic               empty,
    output logic               full
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } qptr_t;

    qptr_t ptr_d, ptr_q;
    logic [ENTRY_W-1:0] slot_q [DEPTH];

    assign empty = (ptr_q.cnt == '0);
    assign full  = (ptr_q.cnt == CNT_W'(DEPTH));
    assign head  = slot_q[ptr_q.rd];

    always_comb begin
        ptr_d = ptr_q;
        if (push) begin
            ptr_d.wr = (ptr_q.wr == PTR_W'(DEPTH - 1)) ? '0 : ptr_q.wr + 1'b1;
        end
        if (pop) begin
            ptr_d.rd = (ptr_q.rd == PTR_W'(DEPTH - 1)) ? '0 : ptr_q.rd + 1'b1;
        end
        case ({push, pop})
            2'b10:   ptr_d.cnt = ptr_q.cnt + 1'b1;
            2'b01:   ptr_d.cnt = ptr_q.cnt - 1'b1;
            default: ptr_d.cnt = ptr_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            slot_q[ptr_q.wr] <= push_data;
        end
    end

    // R7: the controller never posts into a full buffer
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R11: an entry leaves only when one is queued
    assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/wt_line_store.sv
module wt_line_store #(
    parameter int LINES   = 64,
    parameter int WORDS   = 4,
    parameter int DATA_W  = 32,
    parameter int TAG_W   = 22,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_wsel,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WSEL_W-1:0] wr_wsel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BE_W-1:0]   wr_be,
    input  logic              tag_set,
    input  logic [TAG_W-1:0]  tag_val
);

    logic [LINES-1:0]  valid_d, valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] word_q [LINES*WORDS];

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = word_q[{rd_idx, rd_wsel}];

    always_comb begin
        valid_d = valid_q;
        if (tag_set) begin
            valid_d[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < BE_W; b++) begin
                if (wr_be[b]) begin
                    word_q[{wr_idx, wr_wsel}][b*8 +: 8] <= wr_data[b*8 +: 8];
                end
            end
        end
        if (tag_set) begin
            tag_q[wr_idx] <= tag_val;
        end
    end

    // R4: a completed refill leaves its line valid
    assert_fill_sets_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tag_set |=> valid_q[$past(wr_idx)]);

endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
    import wt_dcache_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int DATA_W         = 32,
    parameter int LINES          = 64,
    parameter int LINE_BYTES     = 16,
    parameter int SQ_DEPTH       = 4,
    parameter bit ALLOC_ON_WMISS = 1'b1,
    localparam int BE_W   = DATA_W / 8,
    localparam int BOFF_W = $clog2(BE_W),
    localparam int WORDS  = LINE_BYTES / BE_W,
    localparam int WSEL_W = $clog2(WORDS),
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int IDX_W  = $clog2(LINES),
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
    localparam int ENT_W  = ADDR_W + DATA_W + BE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [BE_W-1:0]   cpu_be,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    output logic [BE_W-1:0]   mem_req_be,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);

    typedef struct packed {
        ctl_state_e        st;
        logic [WSEL_W-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // address fields
    logic [TAG_W-1:0]  a_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [WSEL_W-1:0] a_wsel;
    assign a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign a_idx  = cpu_addr[OFF_W +: IDX_W];
    assign a_wsel = cpu_addr[BOFF_W +: WSEL_W];

    // line store
    logic              ln_valid;
    logic [TAG_W-1:0]  ln_tag;
    logic [DATA_W-1:0] ln_data;
    logic              arr_wr_en, arr_tag_set;
    logic [WSEL_W-1:0] arr_wsel;
    logic [DATA_W-1:0] arr_wdata;
    logic [BE_W-1:0]   arr_be;
    logic              hit;

    wt_line_store #(
        .LINES  (LINES),
        .WORDS  (WORDS),
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W)
    ) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (a_idx),
        .rd_wsel  (a_wsel),
        .rd_valid (ln_valid),
        .rd_tag   (ln_tag),
        .rd_data  (ln_data),
        .wr_en    (arr_wr_en),
        .wr_idx   (a_idx),
        .wr_wsel  (arr_wsel),
        .wr_data  (arr_wdata),
        .wr_be    (arr_be),
        .tag_set  (arr_tag_set),
        .tag_val  (a_tag)
    );

    assign hit       = ln_valid && (ln_tag == a_tag);
    assign cpu_rdata = ln_data;

    // store buffer
    logic             q_push, q_pop, q_empty, q_full;
    logic [ENT_W-1:0] q_head;
    logic [ADDR_W-1:0] h_addr;
    logic [DATA_W-1:0] h_data;
    logic [BE_W-1:0]   h_be;

    wt_store_queue #(
        .ENTRY_W (ENT_W),
        .DEPTH   (SQ_DEPTH)
    ) u_sq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data ({cpu_addr[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}, cpu_wdata, cpu_be}),
        .pop       (q_pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full)
    );

    assign {h_addr, h_data, h_be} = q_head;

    // controller
    always_comb begin
        ctl_d       = ctl_q;
        cpu_ack     = 1'b0;
        q_push      = 1'b0;
        arr_wr_en   = 1'b0;
        arr_tag_set = 1'b0;
        arr_wsel    = a_wsel;
        arr_wdata   = cpu_wdata;
        arr_be      = cpu_be;
        case (ctl_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (!cpu_we) begin
                        if (hit) begin
                            cpu_ack = 1'b1;
                        end else begin
                            ctl_d.st = ST_DRAIN;
                        end
                    end else if (hit || !ALLOC_ON_WMISS) begin
                        if (!q_full) begin
                            cpu_ack   = 1'b1;
                            q_push    = 1'b1;
                            arr_wr_en = hit;
                        end
                    end else begin
                        ctl_d.st = ST_DRAIN;
                    end
                end
            end
            ST_DRAIN: begin
                if (q_empty) begin
                    ctl_d.st = ST_REQ;
                end
            end
            ST_REQ: begin
                ctl_d.cnt = '0;
                if (mem_req_ready) begin
                    ctl_d.st = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_rsp_valid) begin
                    arr_wr_en = 1'b1;
                    arr_wsel  = ctl_q.cnt;
                    arr_wdata = mem_rsp_data;
                    arr_be    = '1;
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == WSEL_W'(WORDS - 1)) begin
                        arr_tag_set = 1'b1;
                        ctl_d.st    = ST_IDLE;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, cnt: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // memory request channel: line read while in ST_REQ, otherwise the buffer head
    always_comb begin
        if (ctl_q.st == ST_REQ) begin
            mem_req_valid = 1'b1;
            mem_req_we    = 1'b0;
            mem_req_addr  = {a_tag, a_idx, {OFF_W{1'b0}}};
            mem_req_wdata = '0;
            mem_req_be    = '0;
        end else begin
            mem_req_valid = !q_empty;
            mem_req_we    = 1'b1;
            mem_req_addr  = h_addr;
            mem_req_wdata = h_data;
            mem_req_be    = h_be;
        end
    end

    assign q_pop = mem_req_valid && mem_req_ready && (ctl_q.st != ST_REQ);

    // R10: a line read never overtakes a posted store
    assert_fill_after_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_we) |-> q_empty);

    // R4: line reads are line aligned
    assert_line_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_we) |-> (mem_req_addr[OFF_W-1:0] == '0));

    // R5: a request waiting for ready holds its content
    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

    // R3: a completed load is always served from a matching valid line
    assert_load_from_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && !cpu_we) |-> (ln_valid && (ln_tag == a_tag)));

endmodule

// File: tb/wt_dcache_tb.sv
`timescale 1ns/1ps

module wt_mem_model #(
    parameter int LAT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hold,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_we,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic [3:0]  req_be,
    output logic        rsp_valid,
    output logic [31:0] rsp_data,
    output logic [31:0] rd_cnt,
    output logic [31:0] wr_cnt,
    output logic [31:0] wr_at_rd,
    output logic [31:0] last_rd_addr,
    output logic [31:0] wlog [16]
);
    logic [31:0] mem [4096];
    logic        busy;
    logic [9:0]  base;
    logic [1:0]  idx;
    int          dly;

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 32'hD000_0000 | (i * 4);
    end

    assign req_ready = !hold && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0; rsp_valid <= 1'b0; rd_cnt <= 0; wr_cnt <= 0;
            wr_at_rd <= 0; last_rd_addr <= 0; idx <= 0; dly <= 0; base <= 0;
            rsp_data <= 0;
        end else begin
            rsp_valid <= 1'b0;
            if (req_valid && req_ready) begin
                if (req_we) begin
                    for (int b = 0; b < 4; b++)
                        if (req_be[b]) mem[req_addr[13:2]][b*8 +: 8] <= req_wdata[b*8 +: 8];
                    wlog[wr_cnt[3:0]] <= req_addr;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    busy <= 1'b1; base <= req_addr[13:4]; idx <= 0; dly <= LAT;
                    rd_cnt <= rd_cnt + 1; wr_at_rd <= wr_cnt; last_rd_addr <= req_addr;
                end
            end
            if (busy) begin
                if (dly != 0) begin
                    dly <= dly - 1;
                end else begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= mem[{base, idx}];
                    idx <= idx + 1'b1;
                    if (idx == 2'd3) busy <= 1'b0;
                end
            end
        end
    end
endmodule

module wt_dcache_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        req   [2];
    logic        we    [2];
    logic [31:0] addr  [2];
    logic [31:0] wdata [2];
    logic [3:0]  be    [2];
    logic        ack   [2];
    logic [31:0] rdata [2];
    logic        mv    [2];
    logic        mr    [2];
    logic        mwe   [2];
    logic [31:0] maddr [2];
    logic [31:0] mwd   [2];
    logic [3:0]  mbe   [2];
    logic        rv    [2];
    logic [31:0] rd    [2];
    logic        hold  [2];
    logic [31:0] rdc   [2];
    logic [31:0] wrc   [2];
    logic [31:0] war   [2];
    logic [31:0] lra   [2];
    logic [31:0] wlog0 [16];
    logic [31:0] wlog1 [16];

    wt_dcache #(.ALLOC_ON_WMISS(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(req[0]), .cpu_we(we[0]), .cpu_addr(addr[0]),
        .cpu_wdata(wdata[0]), .cpu_be(be[0]), .cpu_ack(ack[0]), .cpu_rdata(rdata[0]),
        .mem_req_valid(mv[0]), .mem_req_ready(mr[0]), .mem_req_we(mwe[0]),
        .mem_req_addr(maddr[0]), .mem_req_wdata(mwd[0]), .mem_req_be(mbe[0]),
        .mem_rsp_valid(rv[0]), .mem_rsp_data(rd[0]));

    wt_dcache #(.ALLOC_ON_WMISS(1'b0)) u_dut_wa (
        .clk(clk), .rst_n(rst_n), .cpu_req(req[1]), .cpu_we(we[1]), .cpu_addr(addr[1]),
        .cpu_wdata(wdata[1]), .cpu_be(be[1]), .cpu_ack(ack[1]), .cpu_rdata(rdata[1]),
        .mem_req_valid(mv[1]), .mem_req_ready(mr[1]), .mem_req_we(mwe[1]),
        .mem_req_addr(maddr[1]), .mem_req_wdata(mwd[1]), .mem_req_be(mbe[1]),
        .mem_rsp_valid(rv[1]), .mem_rsp_data(rd[1]));

    wt_mem_model u_m0 (
        .clk(clk), .rst_n(rst_n), .hold(hold[0]), .req_valid(mv[0]), .req_ready(mr[0]),
        .req_we(mwe[0]), .req_addr(maddr[0]), .req_wdata(mwd[0]), .req_be(mbe[0]),
        .rsp_valid(rv[0]), .rsp_data(rd[0]), .rd_cnt(rdc[0]), .wr_cnt(wrc[0]),
        .wr_at_rd(war[0]), .last_rd_addr(lra[0]), .wlog(wlog0));

    wt_mem_model u_m1 (
        .clk(clk), .rst_n(rst_n), .hold(hold[1]), .req_valid(mv[1]), .req_ready(mr[1]),
        .req_we(mwe[1]), .req_addr(maddr[1]), .req_wdata(mwd[1]), .req_be(mbe[1]),
        .rsp_valid(rv[1]), .rsp_data(rd[1]), .rd_cnt(rdc[1]), .wr_cnt(wrc[1]),
        .wr_at_rd(war[1]), .last_rd_addr(lra[1]), .wlog(wlog1));

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [31:0] shadow [2][4096];

    typedef struct packed {
        logic        w;
        logic [31:0] a;
        logic [31:0] d;
        logic [3:0]  b;
        logic        miss_al;
        logic        miss_wa;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 32'h0000_04B0, 32'h0,         4'h0, 1'b1, 1'b1}, // R1 R2 R4: 1200 -> line 11, cold
        '{1'b0, 32'h0000_04BC, 32'h0,         4'h0, 1'b0, 1'b0}, // R3 same line, word 3
        '{1'b1, 32'h0000_04B4, 32'h1122_3344, 4'hF, 1'b0, 1'b0}, // R6 store hit
        '{1'b0, 32'h0000_04B4, 32'h0,         4'h0, 1'b0, 1'b0}, // R6 merged word
        '{1'b1, 32'h0000_08B0, 32'h0000_BEEF, 4'h3, 1'b1, 1'b0}, // R8 R9 store miss, tag 2
        '{1'b0, 32'h0000_08B0, 32'h0,         4'h0, 1'b0, 1'b1}, // R8 R9 R10
        '{1'b0, 32'h0000_04B0, 32'h0,         4'h0, 1'b1, 1'b1}, // R2 evicted
        '{1'b1, 32'h0000_04B0, 32'hAA00_0000, 4'h8, 1'b0, 1'b0}, // R6 one byte lane
        '{1'b0, 32'h0000_04B0, 32'h0,         4'h0, 1'b0, 1'b0}, // R6
        '{1'b0, 32'h0000_00C0, 32'h0,         4'h0, 1'b1, 1'b1}, // R2 line 12 tag 0
        '{1'b0, 32'h0000_04C8, 32'h0,         4'h0, 1'b1, 1'b1}, // R2 line 12 tag 1
        '{1'b0, 32'h0000_00C0, 32'h0,         4'h0, 1'b1, 1'b1}  // R2 conflict again
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic shadow_store(input int k, input logic [31:0] a, input logic [31:0] d,
                                input logic [3:0] b);
        for (int i = 0; i < 4; i++)
            if (b[i]) shadow[k][a[13:2]][i*8 +: 8] = d[i*8 +: 8];
    endtask

    task automatic access(input int k, input logic w, input logic [31:0] a,
                          input logic [31:0] d, input logic [3:0] b,
                          output logic [31:0] got, output int stalls);
        @(negedge clk);
        req[k] = 1'b1; we[k] = w; addr[k] = a; wdata[k] = d; be[k] = b;
        stalls = 0;
        forever begin
            #1;
            if (ack[k]) begin
                got = rdata[k];
                break;
            end
            @(negedge clk);
            stalls++;
        end
        @(posedge clk);
        #1 req[k] = 1'b0;
        if (w) shadow_store(k, a, d, b);
    endtask

    task automatic settle();
        repeat (25) @(negedge clk);
    endtask

    initial begin
        logic [31:0] got;
        int          st;
        logic [31:0] r0, w0;
        for (int k = 0; k < 2; k++) begin
            req[k] = 0; we[k] = 0; addr[k] = 0; wdata[k] = 0; be[k] = 0; hold[k] = 0;
            for (int i = 0; i < 4096; i++) shadow[k][i] = 32'hD000_0000 | (i * 4);
        end
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset ack", {31'd0, ack[0]}, 0);
        chk("R1 reset mem_req_valid", {31'd0, mv[0] | mv[1]}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table walk, both write-miss policies
        for (int k = 0; k < 2; k++) begin
            for (int v = 0; v < NV; v++) begin
                r0 = rdc[k];
                access(k, VEC[v].w, VEC[v].a, VEC[v].d, VEC[v].b, got, st);
                if (!VEC[v].w)
                    chk($sformatf("R3 R4 R6 R10 load data k%0d v%0d", k, v), got, shadow[k][VEC[v].a[13:2]]);
                chk($sformatf("R1 R2 R8 R9 line reads k%0d v%0d", k, v), rdc[k] - r0,
                    {31'd0, (k == 0) ? VEC[v].miss_al : VEC[v].miss_wa});
                if (!VEC[v].w && !((k == 0) ? VEC[v].miss_al : VEC[v].miss_wa))
                    chk($sformatf("R3 hit stalls k%0d v%0d", k, v), st, 0);
            end
            settle();
            chk($sformatf("R5 store count k%0d", k), wrc[k], 3);
        end
        chk("R5 memory word 0x4B4", u_m0.mem[12'h12D], 32'h1122_3344);
        chk("R5 memory word 0x4B0", u_m0.mem[12'h12C], shadow[0][12'h12C]);
        chk("R5 write-around memory 0x8B0", u_m1.mem[12'h22C], shadow[1][12'h22C]);

        // R4: cold load, line-aligned read, then an immediate hit
        r0 = rdc[0];
        access(0, 1'b0, 32'h0000_3F3C, 0, 0, got, st);
        chk("R4 refill data", got, shadow[0][12'hFCF]);
        chk("R4 read address aligned", lra[0], 32'h0000_3F30);
        chk("R4 one line read", rdc[0] - r0, 1);
        chk("R4 miss stalled", {31'd0, st >= 6}, 1);
        access(0, 1'b0, 32'h0000_3F34, 0, 0, got, st);
        chk("R4 ascending word 1", got, shadow[0][12'hFCD]);
        chk("R3 hit after refill", st, 0);

        // R7 R11: fill the buffer while memory is held off
        w0 = wrc[1];
        hold[1] = 1'b1;
        for (int i = 0; i < 4; i++) begin
            access(1, 1'b1, 32'h0000_1000 + i * 4, 32'h5500_0000 + i, 4'hF, got, st);
            chk($sformatf("R7 accepted with room %0d", i), st, 0);
        end
        fork
            begin repeat (6) @(negedge clk); hold[1] = 1'b0; end
            access(1, 1'b1, 32'h0000_1012, 32'h5500_0004, 4'hF, got, st);
        join
        chk("R7 stall while full", {31'd0, (st >= 6) && (st <= 9)}, 1);
        settle();
        chk("R11 write count", wrc[1] - w0, 5);
        for (int i = 0; i < 5; i++)
            chk($sformatf("R11 write order %0d", i), wlog1[(w0 + i) % 16], 32'h0000_1000 + i * 4);
        chk("R5 low address bits cleared", u_m1.mem[12'h404], 32'h5500_0004);

        // R10: posted store, then a load to the same word while memory is held off
        hold[1] = 1'b1;
        access(1, 1'b1, 32'h0000_2000, 32'hCAFE_F00D, 4'hF, got, st);
        fork
            begin repeat (5) @(negedge clk); hold[1] = 1'b0; end
            access(1, 1'b0, 32'h0000_2000, 0, 0, got, st);
        join
        chk("R10 load sees posted store", got, 32'hCAFE_F00D);
        chk("R10 read after all writes", war[1], wrc[1]);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog R1..all actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule